// File: doc/BRIEF.md
# Receive Buffer with Per-Byte Error Tags

This block sits behind the serial deserializer of a 16550-class UART and holds received characters until software reads them. Every stored byte has a small error tag beside it: parity, framing, break and overrun. Error flags are kept with their byte and show in the line-status error bits only when that byte reaches the head of the buffer. Software then sees an error together with the character that caused it, even when several characters are waiting in front of it.

The block raises three requests. The data request fires at a fill level that software selects. The timeout request fires when characters sit unread for four character times. The line-status request fires when a tagged entry reaches the head. The FIFO control write enables the 16-deep mode, selects the trigger level and flushes the buffers. A flush of the transmit side is passed on as a one-cycle pulse. The external baud logic supplies a one-cycle tick per character time, so the timeout needs no knowledge of line settings.

Top module: `uart_rx_fifo`

## Requirements
- R1: During and right after a synchronous reset (rst_n low), the buffer is empty, rx_level is 0, the stored control value is 0x00 (single-entry mode), all three requests are low, and lsr_data and rd_data read 0x00.
- R2: Accepted bytes leave in arrival order. While the buffer holds data, rd_data shows the head byte, and otherwise it shows 0x00. rx_level counts the stored bytes. A rd_pop pulse on an empty buffer changes nothing.
- R3: With control bit 0 set the buffer holds 16 entries. With it clear, it holds 1 entry and the trigger threshold is 1.
- R4: A byte that arrives when the buffer is full, with no read in the same cycle, is dropped and rx_level does not change. The overrun flag (line-status bit 1 when reported) is ORed into the tag of the newest stored entry. A read in the same cycle frees room, so the byte is stored instead.
- R5: rx_err is {break, framing, parity} in bits 2..0. An arriving break also marks framing, so both line-status bit 4 (break) and bit 3 (framing) are reported for that entry. Parity is bit 2.
- R6: Control bits 7:6 pick the threshold: 00→1, 01→4, 10→8, 11→14. rx_irq is set by an accepted arrival that makes the fill level equal the threshold. It is cleared by a read that leaves the level below the threshold.
- R7: Every arrival, including a dropped one, restarts a timer. A read that leaves data also restarts it, and a read that empties the buffer stops it. On the fourth char_tick after a restart without a further restart, to_irq is set. A read of data clears to_irq.
- R8: When an entry becomes the head (arrival into an empty buffer, or a read that exposes the next entry), a nonzero tag is ORed into the error bits 4:1 and ls_irq is set. The same happens when an overrun is merged into the tag of the head entry.
- R9: lsr_data bit 0 is set while the buffer holds data, and bits 6:5 read 0. An lsr_rd pulse clears the error bits and ls_irq unless a new head error is loaded in the same cycle, in which case only the new flags remain.
- R10: lsr_data bit 7 is set in 16-entry mode while any stored entry has a nonzero tag. It falls once the last tagged entry has been read or flushed.
- R11: A control write stores its value with bits 5:4 forced to 0. The receive buffer, its tags and both rx_irq and to_irq are cleared when bit 1 is set or bit 0 changes. A flush takes precedence over an arrival or a read in the same cycle. Bit 2 produces a one-cycle tx_flush pulse on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_byte | input | 8 | Received character |
| rx_err | input | 3 | {break, framing, parity} flags for rx_byte |
| rd_pop | input | 1 | Data read strobe, removes the head byte |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| fcr_q | output | 8 | Stored FIFO control value |
| tx_flush | output | 1 | One-cycle pulse requesting a transmit buffer flush |
| lsr_rd | input | 1 | Line-status read strobe, clears reported errors |
| lsr_data | output | 8 | Receive-side line status |
| char_tick | input | 1 | One-cycle pulse per character time |
| rx_level | output | 5 | Number of stored bytes |
| rx_irq | output | 1 | Receive data request |
| to_irq | output | 1 | Receive timeout request |
| ls_irq | output | 1 | Line-status error request |

## Verification
The assertions rely on every strobe being a clean level, sampled at the rising edge, with no unknown values once reset is released. The rise check for the data request also assumes that the trigger bits were not rewritten in the cycle of the arrival. The bench drives all inputs on the falling edge from a seeded random source. It writes control values only now and then, so long fill and drain phases take place between them. It also pushes the buffer to full and beyond, so the overrun path and the tag merge are exercised under the same rules the checks use.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    // Error tag kept beside each byte; the bit order matches line-status bits 4..1
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } rx_tag_t;

    // Trigger level picked by control bits 7:6
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Byte and tag storage for the receive buffer.
// Decides which arrivals and reads are accepted. Merges overrun flags into the
// newest entry's tag. Reports the tag of any entry that becomes (or is at) the
// head, and keeps a count of tagged entries.
// Assumes DEPTH is a power of two; single-entry mode reuses the same pointers.
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_on,
    input  logic                         flush,
    input  logic                         rx_valid,
    input  logic [DW-1:0]                rx_byte,
    input  rx_tag_t                      rx_tag,
    input  logic                         rd_req,
    output logic                         push_ok,
    output logic                         pop_ok,
    output logic                         overrun,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic [DW-1:0]                head_data,
    output logic                         hl_valid,
    output rx_tag_t                      hl_tag,
    output logic [$clog2(DEPTH+1)-1:0]   tag_cnt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem_d [DEPTH];
    rx_tag_t       mem_t [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr, last_ptr, next_ptr;
    logic [CW-1:0] cap;
    rx_tag_t       head_tag, last_tag, ovr_only;
    logic          inc_tag, dec_tag;

    assign cap       = fifo_on ? CW'(DEPTH) : CW'(1);
    assign last_ptr  = wr_ptr - AW'(1);
    assign next_ptr  = rd_ptr + AW'(1);
    assign head_tag  = mem_t[rd_ptr];
    assign last_tag  = mem_t[last_ptr];
    assign head_data = mem_d[rd_ptr];
    assign ovr_only  = '{brk: 1'b0, frm: 1'b0, par: 1'b0, ovr: 1'b1};

    // Acceptance: a read in the same cycle makes room for an arrival
    always_comb begin
        pop_ok  = rd_req && (level != '0) && !flush;
        push_ok = rx_valid && !flush && ((level < cap) || pop_ok);
        overrun = rx_valid && !flush && (level >= cap) && !pop_ok;
    end

    // Head-change detection and the tag that is exposed
    always_comb begin
        hl_valid = 1'b0;
        hl_tag   = '0;
        if (push_ok && level == '0) begin
            hl_valid = 1'b1;
            hl_tag   = rx_tag;
        end else if (pop_ok && level >= CW'(2)) begin
            hl_valid = 1'b1;
            hl_tag   = mem_t[next_ptr];
        end else if (pop_ok && push_ok) begin
            hl_valid = 1'b1;
            hl_tag   = rx_tag;
        end else if (overrun && level == CW'(1)) begin
            hl_valid = 1'b1;
            hl_tag   = ovr_only;
        end
    end

    assign inc_tag = (push_ok && rx_tag != '0) || (overrun && last_tag == '0);
    assign dec_tag = pop_ok && head_tag != '0;

    // Storage write: new entry, or overrun merge into the newest entry
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_d[wr_ptr] <= rx_byte;
            mem_t[wr_ptr] <= rx_tag;
        end else if (overrun) begin
            mem_t[last_ptr].ovr <= 1'b1;
        end
    end

    // Pointers, fill level and tagged-entry count
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            level   <= '0;
            tag_cnt <= '0;
        end else begin
            if (pop_ok)  rd_ptr <= next_ptr;
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            level   <= level + CW'(push_ok) - CW'(pop_ok);
            tag_cnt <= tag_cnt + CW'(inc_tag) - CW'(dec_tag);
        end
    end

endmodule

// File: rtl/rxq_timer.sv
// Character-time timeout counter.
// Counts char_tick pulses after the last restart and emits a one-cycle fire
// after CHARS ticks. Stop has priority over restart, and restart over counting.
module rxq_timer #(
    parameter int CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic stop,
    input  logic tick,
    output logic fire
);
    localparam int TW = (CHARS > 1) ? $clog2(CHARS) : 1;

    logic          armed;
    logic [TW-1:0] cnt;

    assign fire = armed && tick && !restart && !stop && (cnt == TW'(CHARS - 1));

    // Arm, count ticks and disarm on expiry
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (restart) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && tick) begin
            if (fire) armed <= 1'b0;
            else      cnt   <= cnt + TW'(1);
        end
    end

endmodule

// File: rtl/rxq_status.sv
// Request and line-status error state.
// Holds the data, timeout and line-status requests and the accumulated error
// bits. Assumes the accept and head-change qualifiers come from rxq_store.
module rxq_status
    import uart_rxq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_ok,
    input  logic          pop_ok,
    input  logic [CW-1:0] next_level,
    input  logic [CW-1:0] thr,
    input  logic          fire,
    input  logic          hl_valid,
    input  rx_tag_t       hl_tag,
    input  logic          lsr_rd,
    output logic          rx_irq,
    output logic          to_irq,
    output logic          ls_irq,
    output rx_tag_t       err_bits
);
    // Data request: set at threshold on arrival, cleared below it on read
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                    rx_irq <= 1'b0;
        else if (push_ok && next_level == thr)  rx_irq <= 1'b1;
        else if (pop_ok && next_level < thr)    rx_irq <= 1'b0;
    end

    // Timeout request: set on expiry, cleared by any data read
    always_ff @(posedge clk) begin
        if (!rst_n || flush || pop_ok) to_irq <= 1'b0;
        else if (fire)                 to_irq <= 1'b1;
    end

    // Error bits and line-status request: a head load wins over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_bits <= '0;
            ls_irq   <= 1'b0;
        end else if (hl_valid && hl_tag != '0) begin
            err_bits <= (lsr_rd ? rx_tag_t'('0) : err_bits) | hl_tag;
            ls_irq   <= 1'b1;
        end else if (lsr_rd) begin
            err_bits <= '0;
            ls_irq   <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
// Receive buffer of a 16550-class UART with per-byte error tags.
// Holds the control register, derives the flush and threshold from it, and
// joins storage, timeout and status. Assumes strobes are one cycle wide and that
// char_tick comes from baud logic that already knows the line settings.
module uart_rx_fifo
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int TO_CHARS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [DW-1:0]              rx_byte,
    input  logic [2:0]                 rx_err,
    input  logic                       rd_pop,
    output logic [DW-1:0]              rd_data,
    input  logic                       fcr_we,
    input  logic [7:0]                 fcr_wdata,
    output logic [7:0]                 fcr_q,
    output logic                       tx_flush,
    input  logic                       lsr_rd,
    output logic [7:0]                 lsr_data,
    input  logic                       char_tick,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       rx_irq,
    output logic                       to_irq,
    output logic                       ls_irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic          fifo_on, flush;
    logic          push_ok, pop_ok, overrun, hl_valid, fire;
    logic          restart, stop;
    logic [CW-1:0] next_level, thr, tag_cnt;
    logic [DW-1:0] head_data;
    rx_tag_t       in_tag, hl_tag, err_bits;

    assign fifo_on    = fcr_q[0];
    assign flush      = fcr_we && (fcr_wdata[1] || (fcr_wdata[0] != fcr_q[0]));
    assign thr        = fifo_on ? CW'(trig_level(fcr_q[7:6])) : CW'(1);
    assign in_tag     = '{brk: rx_err[2], frm: rx_err[1] | rx_err[2], par: rx_err[0], ovr: 1'b0};
    assign next_level = rx_level + CW'(push_ok) - CW'(pop_ok);
    assign restart    = (rx_valid && !flush) || (pop_ok && next_level != '0);
    assign stop       = flush || (pop_ok && next_level == '0);
    assign rd_data    = (rx_level != '0) ? head_data : '0;
    assign lsr_data   = {fifo_on && (tag_cnt != '0), 2'b00, err_bits, rx_level != '0};

    // Control register with bits 5:4 masked, and the transmit flush pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcr_q    <= '0;
            tx_flush <= 1'b0;
        end else begin
            tx_flush <= fcr_we && fcr_wdata[2];
            if (fcr_we) fcr_q <= fcr_wdata & 8'hCF;
        end
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .flush(flush),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_tag(in_tag), .rd_req(rd_pop),
        .push_ok(push_ok), .pop_ok(pop_ok), .overrun(overrun), .level(rx_level),
        .head_data(head_data), .hl_valid(hl_valid), .hl_tag(hl_tag), .tag_cnt(tag_cnt)
    );

    rxq_timer #(.CHARS(TO_CHARS)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .stop(stop),
        .tick(char_tick), .fire(fire)
    );

    rxq_status #(.CW(CW)) u_status (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_ok(push_ok), .pop_ok(pop_ok),
        .next_level(next_level), .thr(thr), .fire(fire), .hl_valid(hl_valid),
        .hl_tag(hl_tag), .lsr_rd(lsr_rd), .rx_irq(rx_irq), .to_irq(to_irq),
        .ls_irq(ls_irq), .err_bits(err_bits)
    );

endmodule

// File: rtl/rxq_checker.sv
// Port-level properties of uart_rx_fifo, attached by bind.
module rxq_checker
    import uart_rxq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rd_pop,
    input logic       fcr_we,
    input logic [7:0] fcr_wdata,
    input logic [7:0] fcr_q,
    input logic       lsr_rd,
    input logic [7:0] lsr_data,
    input logic [4:0] rx_level,
    input logic       rx_irq,
    input logic       to_irq,
    input logic       ls_irq
);
    logic [4:0] cap, thr;
    assign cap = fcr_q[0] ? 5'd16 : 5'd1;
    assign thr = fcr_q[0] ? trig_level(fcr_q[7:6]) : 5'd1;

    a_r3_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= cap);

    a_r4_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rd_pop && !fcr_we && rx_level == cap |=> $stable(rx_level));

    a_r6_rise_at_thr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) && !$past(fcr_we) |-> rx_level == thr);

    a_r7_read_clears_to: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop && rx_level != 5'd0 |=> !to_irq);

    a_r8_ls_has_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_irq) |-> lsr_data[4:1] != 4'd0);

    a_r9_lsr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !rx_valid && !rd_pop |=> !ls_irq && lsr_data[4:1] == 4'd0);

    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_we && fcr_wdata[1] |=> rx_level == 5'd0 && !rx_irq && !to_irq);

endmodule

bind uart_rx_fifo rxq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_pop(rd_pop),
    .fcr_we(fcr_we), .fcr_wdata(fcr_wdata), .fcr_q(fcr_q), .lsr_rd(lsr_rd),
    .lsr_data(lsr_data), .rx_level(rx_level), .rx_irq(rx_irq),
    .to_irq(to_irq), .ls_irq(ls_irq)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, rx_valid, rd_pop, fcr_we, lsr_rd, char_tick;
    logic [7:0] rx_byte, rd_data, fcr_wdata, fcr_q, lsr_data;
    logic [2:0] rx_err;
    logic [4:0] rx_level;
    logic       tx_flush, rx_irq, to_irq, ls_irq;

    uart_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_err(rx_err), .rd_pop(rd_pop), .rd_data(rd_data), .fcr_we(fcr_we),
        .fcr_wdata(fcr_wdata), .fcr_q(fcr_q), .tx_flush(tx_flush), .lsr_rd(lsr_rd),
        .lsr_data(lsr_data), .char_tick(char_tick), .rx_level(rx_level),
        .rx_irq(rx_irq), .to_irq(to_irq), .ls_irq(ls_irq)
    );

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [7:0] qd[$];
    logic [3:0] qt[$];
    logic [7:0] m_fcr = 8'h00;
    logic [3:0] m_lsr = 4'h0;
    logic       m_rx = 0, m_to = 0, m_ls = 0, m_txf = 0, m_arm = 0;
    int         m_cnt = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [7:0] f);
        if (!f[0]) return 1;
        case (f[7:6])
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    // One clock cycle: drive, check combinational outputs, step model, check registers
    task automatic cyc(input logic rv, input logic [7:0] rb, input logic [2:0] re,
                       input logic pop, input logic fwe, input logic [7:0] fwd,
                       input logic lrd, input logic tk);
        int sz, cap, nl, thr;
        logic fon, flush, popok, pushok, ovr, hlv, restart, stop, fire, anyt;
        logic [3:0] tag, hl;
        rx_valid = rv; rx_byte = rb; rx_err = re; rd_pop = pop;
        fcr_we = fwe; fcr_wdata = fwd; lsr_rd = lrd; char_tick = tk;
        #1;
        sz = qd.size();
        anyt = 1'b0;
        foreach (qt[k]) if (qt[k] != 4'h0) anyt = 1'b1;
        chk("R2 rd_data", rd_data, (sz != 0) ? qd[0] : 8'h00);
        chk("R9 data-ready", lsr_data[0], sz != 0);
        chk("R9 bits 6:5", lsr_data[6:5], 2'b00);
        chk("R8 error bits", lsr_data[4:1], m_lsr);
        chk("R10 tagged flag", lsr_data[7], m_fcr[0] && anyt);

        fon    = m_fcr[0];
        cap    = fon ? 16 : 1;
        flush  = fwe && (fwd[1] || (fwd[0] != fon));
        popok  = pop && sz != 0 && !flush;
        pushok = rv && !flush && (sz < cap || popok);
        ovr    = rv && !flush && sz >= cap && !popok;
        tag    = {re[2], re[1] | re[2], re[0], 1'b0};
        hlv = 1'b0; hl = 4'h0;
        if (pushok && sz == 0)                 begin hlv = 1; hl = tag; end
        else if (popok && sz >= 2)             begin hlv = 1; hl = qt[1]; end
        else if (popok && pushok)              begin hlv = 1; hl = tag; end
        else if (ovr && sz == 1)               begin hlv = 1; hl = 4'b0001; end
        nl  = sz + int'(pushok) - int'(popok);
        thr = thr_of(m_fcr);
        restart = (rv && !flush) || (popok && nl != 0);
        stop    = flush || (popok && nl == 0);
        fire    = m_arm && tk && !restart && !stop && m_cnt == 3;

        if (flush) begin
            qd.delete(); qt.delete();
        end else begin
            if (popok)  begin void'(qd.pop_front()); void'(qt.pop_front()); end
            if (pushok) begin qd.push_back(rb); qt.push_back(tag); end
            if (ovr)    qt[qt.size()-1] = qt[qt.size()-1] | 4'b0001;
        end
        if (flush)                       m_rx = 0;
        else if (pushok && nl == thr)    m_rx = 1;
        else if (popok && nl < thr)      m_rx = 0;
        if (flush || popok) m_to = 0;
        else if (fire)      m_to = 1;
        if (hlv && hl != 4'h0) begin
            m_lsr = (lrd ? 4'h0 : m_lsr) | hl; m_ls = 1;
        end else if (lrd) begin
            m_lsr = 4'h0; m_ls = 0;
        end
        if (stop)                begin m_arm = 0; m_cnt = 0; end
        else if (restart)        begin m_arm = 1; m_cnt = 0; end
        else if (m_arm && tk)    begin if (fire) m_arm = 0; else m_cnt++; end
        m_txf = fwe && fwd[2];
        if (fwe) m_fcr = fwd & 8'hCF;

        @(posedge clk);
        @(negedge clk);
        chk("R2 level", rx_level, qd.size());
        chk("R6 rx_irq", rx_irq, m_rx);
        chk("R7 to_irq", to_irq, m_to);
        chk("R8 ls_irq", ls_irq, m_ls);
        chk("R11 fcr_q", fcr_q, m_fcr);
        chk("R11 tx_flush", tx_flush, m_txf);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 3'b000, 0, 0, 8'h00, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        rst_n = 0; rx_valid = 0; rx_byte = 0; rx_err = 0; rd_pop = 0;
        fcr_we = 0; fcr_wdata = 0; lsr_rd = 0; char_tick = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 level", rx_level, 0);
        chk("R1 irqs", {rx_irq, to_irq, ls_irq}, 3'b000);
        chk("R1 lsr_data", lsr_data, 8'h00);
        chk("R1 fcr_q", fcr_q, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
        rst_n = 1;

        // R3: single-entry mode holds one byte
        cyc(1, 8'hA1, 3'b000, 0, 0, 8'h00, 0, 0);
        cyc(1, 8'hA2, 3'b000, 0, 0, 8'h00, 0, 0);
        chk("R3 single capacity", rx_level, 1);
        chk("R4 overrun at head", lsr_data[1], 1'b1);
        cyc(0, 8'h00, 3'b000, 1, 0, 8'h00, 1, 0);

        // R11: enable with masked bits, flush
        cyc(0, 8'h00, 3'b000, 0, 1, 8'h77, 0, 0);
        chk("R11 mask 5:4", fcr_q, 8'h47);
        // R3/R4: fill 16, then one more is dropped
        for (int i = 0; i < 16; i++) cyc(1, 8'(i + 16), 3'b000, 0, 0, 8'h00, 0, 0);
        chk("R3 fifo capacity", rx_level, 16);
        cyc(1, 8'hEE, 3'b000, 0, 0, 8'h00, 0, 0);
        chk("R4 level held", rx_level, 16);
        chk("R10 tagged flag after overrun", lsr_data[7], 1'b1);
        for (int i = 0; i < 15; i++) cyc(0, 8'h00, 3'b000, 1, 0, 8'h00, 0, 0);
        chk("R4 newest entry tagged", lsr_data[1], 1'b1);
        chk("R2 last byte kept", rd_data, 8'h1F);
        cyc(0, 8'h00, 3'b000, 1, 0, 8'h00, 1, 0);
        chk("R10 tagged flag cleared", lsr_data[7], 1'b0);

        // R5: break implies framing
        cyc(1, 8'h55, 3'b100, 0, 0, 8'h00, 0, 0);
        chk("R5 break+framing", lsr_data[4:1], 4'b1100);
        cyc(0, 8'h00, 3'b000, 1, 0, 8'h00, 1, 0);

        // R7: timeout after four ticks
        cyc(1, 8'h33, 3'b000, 0, 0, 8'h00, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 3'b000, 0, 0, 8'h00, 0, 1);
        chk("R7 not yet", to_irq, 1'b0);
        cyc(0, 8'h00, 3'b000, 0, 0, 8'h00, 0, 1);
        chk("R7 expired", to_irq, 1'b1);
        cyc(0, 8'h00, 3'b000, 1, 0, 8'h00, 0, 0);
        idle(2);

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic rv, pop, fwe, lrd, tk;
            logic [7:0] fwd;
            logic [2:0] re;
            int ph;
            ph  = (i / 300) % 2;
            rv  = ($urandom % 100) < (ph ? 70 : 30);
            pop = ($urandom % 100) < (ph ? 25 : 65);
            re  = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            lrd = ($urandom % 10) == 0;
            tk  = ($urandom % 4) == 0;
            fwe = ($urandom % 97) == 0;
            fwd = 8'($urandom);
            fwd[0] = ($urandom % 8) != 0;
            fwd[1] = ($urandom % 4) == 0;
            cyc(rv, 8'($urandom), re, pop, fwe, fwd, lrd, tk);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule